// File: doc/BRIEF.md
# Instruction Phase Sequencer

This block is the control heart of a small memory-to-memory processor that keeps no program counter in a register and no accumulator: every operand and result lives in memory or I/O space. The sequencer walks each instruction through up to eighteen numbered phases. It fetches the opcode word, bumps the memory-resident PC, chases the x operand through zero, one or two levels of indirection, does the same for the y operand, runs the ALU, and finally writes the result through its own indirection chain. Which phases are visited depends on the x, y and z addressing-mode fields of the latched opcode and, at the end, on whether the instruction's condition holds.

In every phase the block decodes the one-hot phase into the datapath controls: load enables for the opcode, x and y registers, the read/write strobe, the I/O-space select, the operand gate selects, the address gate, and the ALU function code. The datapath registers, the ALU, the condition evaluator and the clock divider sit outside. A step enable, high for one clock in every processor cycle, paces the state register so that the whole machine can run from a fast clock divided by eight.

Top module: `phase_sequencer`

## Requirements
- R1: While rst_ni is low, and right after it rises, phase_o equals 18'h00001 (phase 0); phase n is shown as bit n of phase_o.
- R2: A clock edge with step_i low leaves phase_o unchanged.
- R3: Phase 0 goes to 1 and 1 goes to 2. From phase 2: x mode (opcode bits 5:4) nonzero goes to 3; otherwise y mode (bits 7:6) nonzero goes to 9 when bits 9:8 equal 01 and to 8 otherwise; with both modes zero it goes to 12.
- R4: From phase 3, x mode 11 goes to 4, 10 goes to 5, 01 goes to 6; phase 4 goes to 5 and phase 5 goes to 6.
- R5: Phase 6 goes to 7 when y mode is nonzero, else to 12. Phase 7 goes to 9 when bits 9:8 equal 01, else to 8; phase 8 goes to 9. From phase 9, y mode 11 goes to 10, 10 goes to 11, 0x goes to 12; phase 10 goes to 11 and 11 goes to 12.
- R6: The effective result mode is bits 9:8, replaced by bits 7:6 when bits 9:8 equal 01. Phase 12 goes to 13 if it is nonzero, else to 0; 13 goes to 14; phase 15 goes to 16 if its low bit is set, else to 17; 16 goes to 17 and 17 goes to 0.
- R7: From phase 14, cond_true_i low goes to 1; high goes to 15 when the effective mode's high bit is set, else to 17.
- R8: load_op_o is high only in phase 1, load_x_o only in phases 6 and 12, and load_y_o is low exactly in phases 1, 3, 8, and in 14 when cond_true_i is high.
- R9: read_o is low (write) exactly in phases 2, 3, 8, 12, 14 and 17.
- R10: io_space_o is high in phase 6 when opcode bits 11, 14 and 5 are all set, and in phase 17 when bits 11 and 12 are both set; low otherwise.
- R11: y_gate_o is low in phase 17 and in phase 12 with y mode 00; x_sel_o[1] is low only in phase 12 with bits 11 and 15 set; x_sel_o[0] is high in phase 17 and in phase 12 with x mode nonzero; addr_gate_o is low in phases 0, 2, 3, 7, 8, 12, 13, 14; alu_fn_o[4] equals bit 13 AND bit 11, and alu_fn_o[3:0] equals bits 3:0 in phase 12 and zero elsewhere.
- R12: phase_o always has exactly one bit set; an encoding without exactly one bit set is replaced by phase 0 at the next step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | One-cycle advance enable per processor cycle |
| opcode_i | input | 16 | Latched opcode word |
| cond_true_i | input | 1 | Instruction condition holds |
| phase_o | output | 18 | One-hot current phase |
| load_op_o | output | 1 | Opcode register load |
| load_x_o | output | 1 | X register load |
| load_y_o | output | 1 | Y register load |
| read_o | output | 1 | 1 read, 0 write |
| io_space_o | output | 1 | Access targets I/O space |
| y_gate_o | output | 1 | Pass y register to ALU (0 forces zero) |
| x_sel_o | output | 2 | X operand mux select |
| addr_gate_o | output | 1 | 1 address from y register, 0 PC slot |
| alu_fn_o | output | 5 | ALU function code |

## Verification
The condition input does two things in phase 14 in the same cycle: it removes the y-register load and it picks the next phase, either the result path or an early return to the opcode fetch of the next instruction. The bench provokes this by running every combination of the six mode bits under both condition values, then judges both the load_y_o level during phase 14 and the phase reached after the step. It also checks that the phase holds steady over a clock with no step.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int NUM_PHASES = 18;
  localparam int OP_W       = 16;
  localparam int MODE_W     = 2;
  localparam int ALU_W      = 4;
  localparam int FN_W       = ALU_W + 1;

  // bit positions the datapath decodes
  localparam int XMODE_LSB = 4;
  localparam int YMODE_LSB = 6;
  localparam int ZMODE_LSB = 8;
  localparam int FLAG_BIT  = 10;
  localparam int EXT_BIT   = 11;
  localparam int ZIO_BIT   = 12;
  localparam int ZSR_BIT   = 13;
  localparam int XIO_BIT   = 14;
  localparam int XSR_BIT   = 15;

  typedef logic [NUM_PHASES-1:0] phase_vec_t;
  typedef logic [MODE_W-1:0]     mode_t;

  typedef struct packed {
    mode_t x_mode;
    mode_t y_mode;
    mode_t z_eff;
    logic  z_alias;
  } route_t;

  typedef struct packed {
    logic             ext_ctl;
    logic             x_sr;
    logic             x_io;
    logic             z_sr;
    logic             z_io;
    logic [ALU_W-1:0] alu;
  } ctl_t;

  localparam phase_vec_t PHASE_IDLE = phase_vec_t'(1);
endpackage

// File: rtl/seq_mode_decode.sv
module seq_mode_decode
  import seq_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output route_t          route_o,
  output ctl_t            ctl_o
);
  mode_t zraw;
  logic  unused_flag;

  assign zraw = opcode_i[ZMODE_LSB +: MODE_W];

  always_comb begin
    route_o.x_mode  = opcode_i[XMODE_LSB +: MODE_W];
    route_o.y_mode  = opcode_i[YMODE_LSB +: MODE_W];
    route_o.z_alias = (zraw == 2'b01);
    // result shares the y address: y mode decides the store path
    route_o.z_eff   = route_o.z_alias ? route_o.y_mode : zraw;
  end

  always_comb begin
    ctl_o.ext_ctl = opcode_i[EXT_BIT];
    ctl_o.x_sr    = opcode_i[XSR_BIT];
    ctl_o.x_io    = opcode_i[XIO_BIT];
    ctl_o.z_sr    = opcode_i[ZSR_BIT];
    ctl_o.z_io    = opcode_i[ZIO_BIT];
    ctl_o.alu     = opcode_i[ALU_W-1:0];
  end

  // flag-update bit is consumed by the ALU, not here
  assign unused_flag = opcode_i[FLAG_BIT];
endmodule

// File: rtl/seq_next_phase.sv
module seq_next_phase
  import seq_pkg::*;
(
  input  phase_vec_t cur_i,
  input  route_t     route_i,
  input  logic       cond_i,
  output phase_vec_t nxt_o
);
  phase_vec_t p;
  phase_vec_t n;
  logic x_any, y_any, z_any, alias_z;
  logic legal;

  assign p       = cur_i;
  assign x_any   = |route_i.x_mode;
  assign y_any   = |route_i.y_mode;
  assign z_any   = |route_i.z_eff;
  assign alias_z = route_i.z_alias;
  assign legal   = $onehot(cur_i);

  always_comb begin
    n     = '0;
    n[0]  = (p[12] & ~z_any) | p[17];
    n[1]  = p[0] | (p[14] & ~cond_i);
    n[2]  = p[1];
    n[3]  = p[2] & x_any;
    n[4]  = p[3] & (route_i.x_mode == 2'b11);
    n[5]  = p[4] | (p[3] & (route_i.x_mode == 2'b10));
    n[6]  = p[5] | (p[3] & (route_i.x_mode == 2'b01));
    n[7]  = p[6] & y_any;
    n[8]  = (p[2] & ~x_any & y_any & ~alias_z) | (p[7] & ~alias_z);
    n[9]  = p[8] | (p[2] & ~x_any & y_any & alias_z) | (p[7] & alias_z);
    n[10] = p[9] & (route_i.y_mode == 2'b11);
    n[11] = p[10] | (p[9] & (route_i.y_mode == 2'b10));
    n[12] = (p[2] & ~x_any & ~y_any) | (p[6] & ~y_any)
          | (p[9] & ~route_i.y_mode[1]) | p[11];
    n[13] = p[12] & z_any;
    n[14] = p[13];
    n[15] = p[14] & cond_i & route_i.z_eff[1];
    n[16] = p[15] & route_i.z_eff[0];
    n[17] = (p[14] & cond_i & ~route_i.z_eff[1])
          | (p[15] & ~route_i.z_eff[0]) | p[16];
  end

  // anything not one-hot, or a dead-end decode, restarts at phase 0
  always_comb begin
    if (legal && $onehot(n)) nxt_o = n;
    else                     nxt_o = PHASE_IDLE;
  end
endmodule

// File: rtl/seq_strobes.sv
module seq_strobes
  import seq_pkg::*;
(
  input  phase_vec_t       cur_i,
  input  ctl_t             ctl_i,
  input  mode_t            x_mode_i,
  input  mode_t            y_mode_i,
  input  logic             cond_i,
  output logic             load_op_o,
  output logic             load_x_o,
  output logic             load_y_o,
  output logic             read_o,
  output logic             io_space_o,
  output logic             y_gate_o,
  output logic [1:0]       x_sel_o,
  output logic             addr_gate_o,
  output logic [FN_W-1:0]  alu_fn_o
);
  phase_vec_t p;
  logic x_ind;

  assign p     = cur_i;
  // x fetched through memory (not immediate, not absent)
  assign x_ind = x_mode_i[1];

  always_comb begin
    load_op_o = p[1];
    load_x_o  = p[6] | p[12];
    load_y_o  = ~(p[1] | p[3] | p[8] | (p[14] & cond_i));
    read_o    = ~(p[2] | p[3] | p[8] | p[12] | p[14] | p[17]);
  end

  always_comb begin
    io_space_o = (p[6] & ctl_i.ext_ctl & ctl_i.x_io & x_ind)
               | (p[17] & ctl_i.ext_ctl & ctl_i.z_io);
  end

  always_comb begin
    y_gate_o    = ~((p[12] & ~(|y_mode_i)) | p[17]);
    x_sel_o[1]  = ~(p[12] & ctl_i.ext_ctl & ctl_i.x_sr);
    x_sel_o[0]  = (p[12] & (|x_mode_i)) | p[17];
    addr_gate_o = ~(p[0] | p[2] | p[3] | p[7] | p[8]
                  | p[12] | p[13] | p[14]);
    alu_fn_o    = {ctl_i.z_sr & ctl_i.ext_ctl,
                   p[12] ? ctl_i.alu : {ALU_W{1'b0}}};
  end
endmodule

// File: rtl/phase_sequencer.sv
module phase_sequencer
  import seq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                step_i,
  input  logic [OP_W-1:0]     opcode_i,
  input  logic                cond_true_i,
  output logic [NUM_PHASES-1:0] phase_o,
  output logic                load_op_o,
  output logic                load_x_o,
  output logic                load_y_o,
  output logic                read_o,
  output logic                io_space_o,
  output logic                y_gate_o,
  output logic [1:0]          x_sel_o,
  output logic                addr_gate_o,
  output logic [FN_W-1:0]     alu_fn_o
);
  phase_vec_t state_q, state_d;
  route_t     route;
  ctl_t       ctl;

  seq_mode_decode u_dec (
    .opcode_i (opcode_i),
    .route_o  (route),
    .ctl_o    (ctl)
  );

  seq_next_phase u_next (
    .cur_i   (state_q),
    .route_i (route),
    .cond_i  (cond_true_i),
    .nxt_o   (state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= PHASE_IDLE;
    else if (step_i) state_q <= state_d;
  end

  seq_strobes u_str (
    .cur_i       (state_q),
    .ctl_i       (ctl),
    .x_mode_i    (route.x_mode),
    .y_mode_i    (route.y_mode),
    .cond_i      (cond_true_i),
    .load_op_o   (load_op_o),
    .load_x_o    (load_x_o),
    .load_y_o    (load_y_o),
    .read_o      (read_o),
    .io_space_o  (io_space_o),
    .y_gate_o    (y_gate_o),
    .x_sel_o     (x_sel_o),
    .addr_gate_o (addr_gate_o),
    .alu_fn_o    (alu_fn_o)
  );

  assign phase_o = state_q;

  assert_onehot_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(state_q));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(state_q));

  assert_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && state_q[17]) |=> state_q[0]);

  assert_skip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && state_q[14] && !cond_true_i) |=> state_q[1]);

  assert_io_phase_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_space_o |-> (read_o ? state_q[6] : state_q[17]));

  assert_fetch_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_op_o |-> read_o);
endmodule

// File: tb/phase_sequencer_test.sv
module phase_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [15:0] op = '0;
  logic        cc = 1'b0;
  logic [17:0] phase;
  logic        ld_op, ld_x, ld_y, rd, io, yg, ag;
  logic [1:0]  xs;
  logic [4:0]  fn;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  phase_sequencer uut (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .opcode_i(op),
    .cond_true_i(cc), .phase_o(phase), .load_op_o(ld_op), .load_x_o(ld_x),
    .load_y_o(ld_y), .read_o(rd), .io_space_o(io), .y_gate_o(yg),
    .x_sel_o(xs), .addr_gate_o(ag), .alu_fn_o(fn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h op=%04h cc=%0b", tag, act, exp, op, cc);
    end
  endtask

  function automatic int nxt(input int p, input logic [15:0] b, input logic c);
    logic [1:0] xm, ym, ze;
    logic al;
    xm = b[5:4]; ym = b[7:6]; al = (b[9:8] == 2'b01);
    ze = al ? ym : b[9:8];
    case (p)
      0: return 1;
      1: return 2;
      2: return (xm != 0) ? 3 : (ym != 0) ? (al ? 9 : 8) : 12;
      3: return (xm == 3) ? 4 : (xm == 2) ? 5 : 6;
      4: return 5;
      5: return 6;
      6: return (ym != 0) ? 7 : 12;
      7: return al ? 9 : 8;
      8: return 9;
      9: return (ym == 3) ? 10 : (ym == 2) ? 11 : 12;
      10: return 11;
      11: return 12;
      12: return (ze != 0) ? 13 : 0;
      13: return 14;
      14: return !c ? 1 : ze[1] ? 15 : 17;
      15: return ze[0] ? 16 : 17;
      16: return 17;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int p);
    if (p <= 2) return "R3 branch";
    if (p <= 5) return "R4 x chain";
    if (p <= 11) return "R5 y chain";
    if (p == 14) return "R7 cond";
    return "R6 result";
  endfunction

  task automatic chk_outputs(input int p);
    logic e_ldy, e_rd, e_io;
    e_ldy = !(p == 1 || p == 3 || p == 8 || (p == 14 && cc));
    chk("R8 loads", {ld_op, ld_x, ld_y}, {p == 1, p == 6 || p == 12, e_ldy});
    e_rd = !(p == 2 || p == 3 || p == 8 || p == 12 || p == 14 || p == 17);
    chk("R9 read", rd, e_rd);
    e_io = (p == 6 && op[11] && op[14] && op[5]) || (p == 17 && op[11] && op[12]);
    chk("R10 io", io, e_io);
    chk("R11 gates",
        {yg, xs, ag, fn},
        {!((p == 12 && op[7:6] == 0) || p == 17),
         !(p == 12 && op[11] && op[15]),
         (p == 12 && op[5:4] != 0) || p == 17,
         !(p == 0 || p == 2 || p == 3 || p == 7 || p == 8 || p == 12 || p == 13 || p == 14),
         op[13] & op[11], (p == 12) ? op[3:0] : 4'h0});
    chk("R12 onehot", $countones(phase), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int m = 0; m < 64; m++) begin
      for (int c = 0; c < 2; c++) begin
        logic [5:0] mb;
        int p, prev;
        mb = 6'(m);
        cc = c[0];
        op = {mb[5:2] ^ {cc, cc, ~cc, cc}, mb[0] ^ cc, mb[1], mb, mb[3:0] ^ 4'h5};
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk("R1 in reset", phase, 18'h00001);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", phase, 18'h00001);
        p = 0;
        chk_outputs(p);
        for (int s = 0; s < 20; s++) begin
          prev = p;
          p = nxt(p, op, cc);
          @(negedge clk) step = 1'b1;
          @(negedge clk) step = 1'b0;
          chk(tag_of(prev), phase, 32'(1) << p);
          chk_outputs(p);
          @(negedge clk);
          chk("R2 hold", phase, 32'(1) << p);
          if (p == 0 || (p == 1 && prev == 14)) break;
        end
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule